// File: doc/BRIEF.md
# Simultaneous-Sample Conversion Sequencer

This block is the digital control side of a four-channel converter that samples all its inputs at the same instant and then digitises them one after another. A rising edge on the convert-start input captures every channel's sample value at once. The block then works through the enabled channels from lowest to highest, spending a fixed number of clock cycles on each. It stores each 12-bit result and pulses an end-of-conversion strobe as each one lands. While any channel is pending, the busy output stays high.

A host reads results back through an active-low parallel interface (chip select, read, write). A read pointer walks the stored results in ascending channel order and wraps to the first result after the last one. A first-data flag marks when the pointer sits on the first result. The channel set comes either from four select pins or from a mask the host writes over the bus, chosen by a mode input. A standby input makes the block ignore convert-start. The analog conversion itself is abstract: the result for a channel is the sample value captured at the start edge, released after `CONV_CYCLES` clocks.

Top module: `simsamp_seq`

## Requirements
- R1: The enabled channels are converted strictly in ascending channel index, and successive reads return their results in that same order, skipping disabled channels.
- R2: With `sel_mode` = 0 the channel mask is `sel_pins`. With `sel_mode` = 1 it is a host register. That register is loaded from `host_din` (bit i enables channel i) on a rising edge of `wr_n` while `cs_n` is low, and it holds all ones after reset.
- R3: `busy` goes high in the cycle after the clock edge that first sees `conv_start` high, and stays high for exactly N × `CONV_CYCLES` cycles, where N is the number of enabled channels.
- R4: `eoc` is a one-cycle pulse given once per converted channel, every `CONV_CYCLES` cycles. The last pulse is in the first cycle after `busy` falls.
- R5: Once `busy` is low, each read (rising edge of `rd_n` while `cs_n` is low) moves the pointer to the next stored result. The read that returns the last result moves it back to the first.
- R6: `first_flag` is high exactly when the read pointer addresses the first result of the sequence.
- R7: While `busy` is high, the pointer follows the newest stored result and reads do not move it. When the sequence starts, and again when its last result is stored, the pointer is set to the first result.
- R8: While `stby_n` is low, convert-start edges are ignored and `busy` stays low.
- R9: A convert-start edge while `busy` is high is ignored and does not lengthen the sequence. With an empty mask, `busy` and `eoc` stay low and the stored results and pointer are unchanged.
- R10: `dout_oe` is high only while both `cs_n` and `rd_n` are low. While it is low, `host_dout` is all zeros.
- R11: After reset, `busy` and `eoc` are low, `first_flag` is high and `dout_oe` is low.
- R12: All channel samples are captured at the start edge. Changes on `sample_in` during the sequence do not alter the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Host chip select, active low |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low |
| conv_start | input | 1 | Convert-start; a rising edge begins a sequence |
| stby_n | input | 1 | Low puts the block in standby |
| sel_mode | input | 1 | 0: mask from pins, 1: mask from host register |
| sel_pins | input | NCH | Channel-enable pins |
| host_din | input | NCH | Host write lines carrying the channel mask |
| sample_in | input | NCH×DW | Per-channel sample values, channel i at bits [i×DW +: DW] |
| host_dout | output | DW | Read data |
| dout_oe | output | 1 | Output enable for the data bus |
| busy | output | 1 | Sequence in progress |
| eoc | output | 1 | One-cycle pulse per stored result |
| first_flag | output | 1 | Pointer addresses the first result |

## Verification
On every cycle, the assertions check these relations: every rise of `busy` has a convert-start edge and standby high behind it, `eoc` pulses fall exactly on the per-channel cycle grid, the pointer sits on the first result whenever `busy` rises or falls, and the data bus is zero whenever it is not enabled. Other behaviour can only be shown by the bench's scenarios. This covers the ascending read order over several channel subsets and both mask sources, the pointer wrap, the results staying frozen after the input samples change, the pointer staying put during a read made mid-sequence, and restarts being ignored under standby, while busy, or with an empty mask.

// File: rtl/sseq_pkg.sv
package sseq_pkg;

  // Where the active channel mask comes from.
  typedef enum logic {
    SRC_PINS = 1'b0,
    SRC_HOST = 1'b1
  } mask_src_e;

endpackage

// File: rtl/sseq_strobe.sv
// Registers a vector of strobes and flags rising edges.
module sseq_strobe #(
  parameter int            W       = 1,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sig_i,
  output logic [W-1:0] rise_o
);

  logic [W-1:0] prev_q, prev_d;

  always_comb begin
    prev_d = sig_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= prev_d;
  end

  assign rise_o = sig_i & ~prev_q;

endmodule

// File: rtl/sseq_engine.sv
// Steps through the enabled channels, lowest first, one per CONV_CYCLES.
module sseq_engine #(
  parameter int  NCH         = 4,
  parameter int  DW          = 12,
  parameter int  CONV_CYCLES = 5,
  localparam int IW          = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic [NCH-1:0]    mask_in,
  input  logic [NCH*DW-1:0] samp_in,
  output logic              busy_o,
  output logic              eoc_o,
  output logic              start_o,
  output logic              fin_o,
  output logic              fin_last_o,
  output logic [IW-1:0]     fin_idx_o,
  output logic [DW-1:0]     fin_data_o
);

  localparam int            CW    = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CW-1:0] CLAST = CW'(CONV_CYCLES - 1);

  logic              busy_q, busy_d;
  logic              eoc_q, eoc_d;
  logic [NCH-1:0]    pend_q, pend_d, cur_oh, pend_left;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [NCH*DW-1:0] hold_q, hold_d;
  logic [IW-1:0]     done_q, done_d, cur_idx;
  logic              start, fin;

  // Lowest pending channel; the downward loop lets the smallest index win.
  always_comb begin
    cur_idx = '0;
    cur_oh  = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pend_q[i]) begin
        cur_idx   = IW'(i);
        cur_oh    = '0;
        cur_oh[i] = 1'b1;
      end
    end
  end

  assign pend_left = pend_q & ~cur_oh;
  assign start     = start_req && !busy_q && (|mask_in);
  assign fin       = busy_q && (cnt_q == CLAST);

  always_comb begin
    busy_d = busy_q;
    pend_d = pend_q;
    cnt_d  = cnt_q;
    hold_d = hold_q;
    done_d = done_q;
    eoc_d  = fin;
    if (start) begin
      busy_d = 1'b1;
      pend_d = mask_in;
      cnt_d  = '0;
      hold_d = samp_in;
      done_d = '0;
    end else if (fin) begin
      pend_d = pend_left;
      busy_d = |pend_left;
      cnt_d  = '0;
      done_d = done_q + IW'(1);
    end else if (busy_q) begin
      cnt_d  = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      eoc_q  <= 1'b0;
      pend_q <= '0;
      cnt_q  <= '0;
      hold_q <= '0;
      done_q <= '0;
    end else begin
      busy_q <= busy_d;
      eoc_q  <= eoc_d;
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
      hold_q <= hold_d;
      done_q <= done_d;
    end
  end

  assign busy_o     = busy_q;
  assign eoc_o      = eoc_q;
  assign start_o    = start;
  assign fin_o      = fin;
  assign fin_last_o = ~|pend_left;
  assign fin_idx_o  = done_q;
  assign fin_data_o = hold_q[int'(cur_idx)*DW +: DW];

endmodule

// File: rtl/sseq_rbuf.sv
// Result slots in conversion order plus the self-wrapping read pointer.
module sseq_rbuf #(
  parameter int  NCH = 4,
  parameter int  DW  = 12,
  localparam int IW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          fin_i,
  input  logic          fin_last_i,
  input  logic [IW-1:0] fin_idx_i,
  input  logic [DW-1:0] fin_data_i,
  input  logic          busy_i,
  input  logic          rd_adv_i,
  output logic          ptr_first_o,
  output logic [DW-1:0] rd_data_o
);

  localparam int NW = $clog2(NCH + 1);

  logic [IW-1:0] ptr_q, ptr_d;
  logic [NW-1:0] nres_q, nres_d;
  logic [DW-1:0] slot_q [NCH];
  logic          at_last;

  for (genvar g = 0; g < NCH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 slot_q[g] <= '0;
      else if (fin_i && (fin_idx_i == IW'(g)))    slot_q[g] <= fin_data_i;
    end
  end

  assign at_last = (NW'(ptr_q) == (nres_q - NW'(1)));

  always_comb begin
    ptr_d  = ptr_q;
    nres_d = nres_q;
    if (start_i) begin
      ptr_d  = '0;
      nres_d = '0;
    end else if (fin_i) begin
      nres_d = NW'(fin_idx_i) + NW'(1);
      ptr_d  = fin_last_i ? '0 : fin_idx_i;
    end else if (rd_adv_i && !busy_i && (nres_q != '0)) begin
      ptr_d  = at_last ? '0 : ptr_q + IW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      nres_q <= '0;
    end else begin
      ptr_q  <= ptr_d;
      nres_q <= nres_d;
    end
  end

  assign ptr_first_o = (ptr_q == '0);
  assign rd_data_o   = slot_q[ptr_q];

endmodule

// File: rtl/simsamp_seq.sv
module simsamp_seq
  import sseq_pkg::*;
#(
  parameter int NCH         = 4,
  parameter int DW          = 12,
  parameter int CONV_CYCLES = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              conv_start,
  input  logic              stby_n,
  input  logic              sel_mode,
  input  logic [NCH-1:0]    sel_pins,
  input  logic [NCH-1:0]    host_din,
  input  logic [NCH*DW-1:0] sample_in,
  output logic [DW-1:0]     host_dout,
  output logic              dout_oe,
  output logic              busy,
  output logic              eoc,
  output logic              first_flag
);

  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [2:0]     rise;
  logic [NCH-1:0] soft_q, soft_d, mask;
  logic           conv_rise, rd_adv, wr_hit;
  logic           start, fin, fin_last;
  logic [IW-1:0]  fin_idx;
  logic [DW-1:0]  fin_data, rd_data;

  // {convert-start, read, write}; the strobes idle high, convert-start low.
  sseq_strobe #(.W(3), .RST_VAL(3'b011)) strobe_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_i  ({conv_start, rd_n, wr_n}),
    .rise_o (rise)
  );

  assign conv_rise = rise[2];
  assign rd_adv    = rise[1] & ~cs_n;
  assign wr_hit    = rise[0] & ~cs_n;

  always_comb begin
    soft_d = soft_q;
    if (wr_hit) soft_d = host_din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) soft_q <= '1;
    else        soft_q <= soft_d;
  end

  assign mask = (mask_src_e'(sel_mode) == SRC_HOST) ? soft_q : sel_pins;

  sseq_engine #(.NCH(NCH), .DW(DW), .CONV_CYCLES(CONV_CYCLES)) engine_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_req  (conv_rise & stby_n),
    .mask_in    (mask),
    .samp_in    (sample_in),
    .busy_o     (busy),
    .eoc_o      (eoc),
    .start_o    (start),
    .fin_o      (fin),
    .fin_last_o (fin_last),
    .fin_idx_o  (fin_idx),
    .fin_data_o (fin_data)
  );

  sseq_rbuf #(.NCH(NCH), .DW(DW)) rbuf_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start),
    .fin_i       (fin),
    .fin_last_i  (fin_last),
    .fin_idx_i   (fin_idx),
    .fin_data_i  (fin_data),
    .busy_i      (busy),
    .rd_adv_i    (rd_adv),
    .ptr_first_o (first_flag),
    .rd_data_o   (rd_data)
  );

  assign dout_oe   = ~cs_n & ~rd_n;
  assign host_dout = dout_oe ? rd_data : '0;

endmodule

// File: rtl/sseq_chk.sv
module sseq_chk #(
  parameter int DW          = 12,
  parameter int CONV_CYCLES = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          conv_start,
  input logic          stby_n,
  input logic          busy,
  input logic          eoc,
  input logic          first_flag,
  input logic          dout_oe,
  input logic [DW-1:0] host_dout
);

  localparam int            CW    = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CW-1:0] CLAST = CW'(CONV_CYCLES - 1);

  // Independent phase counter over the busy window.
  logic [CW-1:0] ph_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ph_q <= '0;
    else if (busy)    ph_q <= (ph_q == CLAST) ? '0 : ph_q + CW'(1);
    else              ph_q <= '0;
  end

  // R3
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(conv_start));

  // R8
  busy_stby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stby_n));

  // R4
  eoc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |=> !eoc);

  // R4
  eoc_grid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |-> ($past(busy) && ($past(ph_q) == CLAST)));

  // R4
  eoc_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && ($past(ph_q) == CLAST)) |-> eoc);

  // R7
  ptr_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> first_flag);

  // R7
  ptr_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> first_flag);

  // R10
  bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_oe |-> (host_dout == '0));

endmodule

bind simsamp_seq sseq_chk #(.DW(DW), .CONV_CYCLES(CONV_CYCLES)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .conv_start (conv_start),
  .stby_n     (stby_n),
  .busy       (busy),
  .eoc        (eoc),
  .first_flag (first_flag),
  .dout_oe    (dout_oe),
  .host_dout  (host_dout)
);

// File: tb/simsamp_seq_tb_top.sv
`timescale 1ns/1ps
module simsamp_seq_tb_top;

  localparam int NCH = 4;
  localparam int DW  = 12;
  localparam int C   = 5;

  // {mode, pins[3:0], host mask[3:0]}
  localparam logic [8:0] VEC [6] = '{
    9'b0_1111_0000,
    9'b0_0101_1111,
    9'b1_0000_1010,
    9'b0_1000_0000,
    9'b1_1111_0110,
    9'b0_1011_0000
  };

  logic              clk = 1'b0;
  logic              rst_n, cs_n, rd_n, wr_n, conv_start, stby_n, sel_mode;
  logic [NCH-1:0]    sel_pins, host_din;
  logic [NCH*DW-1:0] sample_in;
  logic [DW-1:0]     host_dout;
  logic              dout_oe, busy, eoc, first_flag;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  simsamp_seq #(.NCH(NCH), .DW(DW), .CONV_CYCLES(C)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .conv_start(conv_start), .stby_n(stby_n), .sel_mode(sel_mode),
    .sel_pins(sel_pins), .host_din(host_din), .sample_in(sample_in),
    .host_dout(host_dout), .dout_oe(dout_oe), .busy(busy), .eoc(eoc),
    .first_flag(first_flag)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int sval(input int v, input int ch);
    return v * 64 + ch * 17 + 3;
  endfunction

  task automatic set_samples(input int v);
    for (int ch = 0; ch < NCH; ch++) sample_in[ch*DW +: DW] = DW'(sval(v, ch));
  endtask

  task automatic host_write(input logic [NCH-1:0] m);
    cs_n = 1'b0; wr_n = 1'b0; host_din = m;
    @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk);
    cs_n = 1'b1;
  endtask

  task automatic host_read(output logic [DW-1:0] d, output logic oe);
    cs_n = 1'b0; rd_n = 1'b0;
    @(negedge clk);
    d = host_dout; oe = dout_oe;
    rd_n = 1'b1;
    @(negedge clk);
    cs_n = 1'b1;
  endtask

  task automatic pulse_start;
    conv_start = 1'b1;
    @(negedge clk);
    conv_start = 1'b0;
  endtask

  task automatic run_seq(output int bc, output int ec, input int pulse_at);
    bc = 0; ec = 0;
    while (busy && !done) begin
      bc++;
      if (eoc) ec++;
      if (bc == 1) sample_in = ~sample_in;
      conv_start = (bc == pulse_at);
      @(negedge clk);
    end
    if (eoc) ec++;
    conv_start = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int bc, ec;
    logic [DW-1:0] d;
    logic oe;
    rst_n = 1'b0; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; conv_start = 1'b0;
    stby_n = 1'b1; sel_mode = 1'b0; sel_pins = '0; host_din = '0; sample_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    check("R11 busy", busy, 0);
    check("R11 eoc", eoc, 0);
    check("R11 first_flag", first_flag, 1);
    check("R11 dout_oe", dout_oe, 0);

    // R2 host mask is all ones after reset
    sel_mode = 1'b1; sel_pins = 4'b0001; set_samples(9);
    pulse_start;
    run_seq(bc, ec, -1);
    check("R2 reset host mask busy length", bc, 4 * C);

    // Vector table: R1 R2 R3 R4 R5 R6 R12
    for (int v = 0; v < 6; v++) begin
      logic [8:0]     e;
      logic [NCH-1:0] m;
      int n;
      int expv [4];
      e = VEC[v];
      if (e[8]) host_write(e[3:0]);
      sel_mode = e[8]; sel_pins = e[7:4];
      m = e[8] ? e[3:0] : e[7:4];
      n = 0;
      for (int ch = 0; ch < NCH; ch++) if (m[ch]) begin expv[n] = sval(v, ch); n++; end
      set_samples(v);
      pulse_start;
      run_seq(bc, ec, -1);
      check("R3 busy length", bc, n * C);
      check("R4 eoc count", ec, n);
      check("R6 first_flag before reads", first_flag, 1);
      for (int i = 0; i < n; i++) begin
        host_read(d, oe);
        check("R1 R12 R2 read data", d, expv[i]);
        check("R10 oe during read", oe, 1);
        check("R5 R6 first_flag after read", first_flag, (i == n - 1) ? 1 : 0);
      end
      host_read(d, oe);
      check("R5 wrap to first", d, expv[0]);
    end

    // R7 read during the sequence
    sel_mode = 1'b0; sel_pins = 4'b1111; set_samples(8);
    pulse_start;
    repeat (2 * C) @(negedge clk);
    check("R7 busy mid sequence", busy, 1);
    check("R7 pointer on newest", first_flag, 0);
    host_read(d, oe);
    check("R7 mid read data", d, sval(8, 1));
    check("R7 read does not move pointer", first_flag, 0);
    run_seq(bc, ec, -1);
    check("R7 pointer back at first", first_flag, 1);

    // R8 standby ignores convert-start
    stby_n = 1'b0;
    pulse_start;
    repeat (2) @(negedge clk);
    check("R8 standby busy", busy, 0);
    stby_n = 1'b1;

    // R9 restart during busy ignored
    sel_pins = 4'b0011; set_samples(7);
    pulse_start;
    run_seq(bc, ec, C + 1);
    check("R9 busy length with restart", bc, 2 * C);
    check("R9 eoc count with restart", ec, 2);

    // R9 empty mask
    sel_pins = 4'b0000;
    pulse_start;
    repeat (3) begin
      check("R9 empty busy", busy, 0);
      check("R9 empty eoc", eoc, 0);
      @(negedge clk);
    end
    check("R9 empty pointer", first_flag, 1);
    host_read(d, oe);
    check("R9 empty keeps results", d, sval(7, 0));

    // R10 bus idle cases
    cs_n = 1'b0; rd_n = 1'b1;
    #1;
    check("R10 oe cs only", dout_oe, 0);
    check("R10 dout zero", host_dout, 0);
    cs_n = 1'b1; rd_n = 1'b0;
    #1;
    check("R10 oe rd only", dout_oe, 0);
    rd_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule